// File: doc/BRIEF.md
# CBC AES-128 Encryption Engine

This block encrypts 128-bit data blocks with AES-128 in cipher-block-chaining mode. A plaintext block enters over a valid/ready port. It is XORed with the chaining value and then walked through the cipher one round per clock. The ciphertext leaves over a second valid/ready port, and the same value becomes the chaining value for the next block. The chaining value is the previous ciphertext, or an initialization vector that a start-of-message pulse loads. Only one block is in flight at a time. The input side stays closed from the moment a block is taken until its ciphertext has been handed off.

The engine does not expand keys. The host writes the eleven unrolled 128-bit round keys into a small key store through a dedicated write port. The round sequencer reads that store once per round, and these reads have priority. A host write that arrives while rounds are running is held off with a ready signal until the engine stops reading. The write is then committed, never lost. State bytes are ordered column-major, so byte 0 (row 0, column 0) sits at bits [127:120] of every 128-bit word.

Top module: `cbc_aes_enc`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and key_wr_ready is 1.
- R2: With the standard AES-128 round keys loaded (key store entry k holds round key k, byte 0 at bits [127:120]) and a zero chaining value, a block produces the standard AES-128 forward-cipher result. The 2b7e1516... key and the 3243f6a8... plaintext give 3925841d02dc09fbdc118597196a0b32.
- R3: Each block is XORed with the previous ciphertext of the same message before the first key addition.
- R4: A msg_start pulse seen while in_ready is 1 loads the chaining value from iv_in. A block accepted in that same cycle is XORed with iv_in directly.
- R5: A msg_start pulse while a block is in flight (in_ready 0) has no effect on the chaining value.
- R6: in_ready drops in the cycle after a block is accepted and stays low until the output handshake. out_valid rises exactly 11 clock cycles after the accepting edge, and in_ready returns to 1 in the cycle after the output handshake.
- R7: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data holds its value.
- R8: During the 11 round cycles, key_wr_ready is 0. A held host write is stalled and commits once the rounds end, so the next block uses the new key. The block already running uses the old key.
- R9: With no rounds running, key_wr_ready is 1 and a write to an address below 11 commits at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_start | input | 1 | Start-of-message pulse; loads chaining value from iv_in when idle |
| iv_in | input | 128 | Initialization vector |
| in_valid | input | 1 | Plaintext block valid |
| in_ready | output | 1 | Engine can accept a plaintext block |
| in_data | input | 128 | Plaintext block |
| out_valid | output | 1 | Ciphertext valid |
| out_ready | input | 1 | Consumer takes the ciphertext |
| out_data | output | 128 | Ciphertext block |
| key_wr_en | input | 1 | Host round-key write request (hold until key_wr_ready) |
| key_wr_addr | input | 4 | Round-key index 0..10 |
| key_wr_data | input | 128 | Round-key value |
| key_wr_ready | output | 1 | Host write is committed this cycle if requested |

## Verification
The bench targets the standard vector, multi-block chains under random output backpressure, and message restarts. A restart is tested both alone and coincident with a block accept. A design that used the stale chaining register in the coincident case would mis-encrypt the first block of the new message. The bench also pulses msg_start while a block is in flight. A design that obeyed that pulse would break the chain of the following block. A host key write is held across a running block. Dropping the write would leave the next ciphertext wrong, and committing it early would corrupt the running block. The exact 11-cycle latency and the closed input gate are measured directly, so an off-by-one round count or an early reopen of the input is caught.

// File: rtl/aes_pkg.sv
package aes_pkg;
  localparam int BLK = 128;
  localparam int NBYTES = BLK / 8;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} eng_state_t;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] aa;
    p = 8'h00;
    aa = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ aa;
      aa = xt(aa);
    end
    return p;
  endfunction

  // inverse as x^254, then the forward affine map
  function automatic logic [7:0] sbox_f(input logic [7:0] x);
    logic [7:0] sq;
    logic [7:0] inv;
    sq = x;
    inv = 8'h01;
    for (int i = 1; i < 8; i++) begin
      sq = gf_mul(sq, sq);
      inv = gf_mul(inv, sq);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
               ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  // byte index 4*col+row sits at bits [127-8*idx -: 8]
  function automatic logic [BLK-1:0] shift_rows_f(input logic [BLK-1:0] s);
    logic [BLK-1:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[BLK-1-8*(4*c+r) -: 8] = s[BLK-1-8*(4*((c+r)%4)+r) -: 8];
    return o;
  endfunction

  function automatic logic [31:0] mix_col_f(input logic [31:0] col);
    logic [7:0] a0, a1, a2, a3;
    a0 = col[31:24];
    a1 = col[23:16];
    a2 = col[15:8];
    a3 = col[7:0];
    return {xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3,
            a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3,
            a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3,
            xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3)};
  endfunction
endpackage

// File: rtl/aes_keystore.sv
module aes_keystore import aes_pkg::*; #(
  parameter int ENTRIES = 11,
  parameter int AW = 4
) (
  input  logic           clk,
  input  logic           rd_en,
  input  logic [AW-1:0]  rd_addr,
  output logic [BLK-1:0] rd_data,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [BLK-1:0] wr_data,
  output logic           wr_ready,
  output logic           wr_fire
);
  localparam logic [AW-1:0] TOP = AW'(ENTRIES);

  logic [BLK-1:0] mem [ENTRIES];

  // engine reads win; a host write waits for a free cycle
  assign wr_ready = ~rd_en;
  assign wr_fire  = wr_en & wr_ready & (wr_addr < TOP);

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_addr] <= wr_data;
  end

  assign rd_data = (rd_addr < TOP) ? mem[rd_addr] : '0;
endmodule

// File: rtl/aes_round_unit.sv
module aes_round_unit import aes_pkg::*; (
  input  logic [BLK-1:0] state_in,
  input  logic [BLK-1:0] round_key,
  input  logic           first,
  input  logic           last,
  output logic [BLK-1:0] state_out
);
  logic [BLK-1:0] sub_b;
  logic [BLK-1:0] shf_b;
  logic [BLK-1:0] mix_b;

  for (genvar i = 0; i < NBYTES; i++) begin : g_sbox
    assign sub_b[BLK-1-8*i -: 8] = sbox_f(state_in[BLK-1-8*i -: 8]);
  end

  assign shf_b = shift_rows_f(sub_b);

  for (genvar c = 0; c < 4; c++) begin : g_mix
    assign mix_b[BLK-1-32*c -: 32] = mix_col_f(shf_b[BLK-1-32*c -: 32]);
  end

  always_comb begin
    if (first)     state_out = state_in ^ round_key;
    else if (last) state_out = shf_b ^ round_key;
    else           state_out = mix_b ^ round_key;
  end
endmodule

// File: rtl/aes_cbc_ctrl.sv
module aes_cbc_ctrl import aes_pkg::*; #(
  parameter int NR = 10,
  parameter int AW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           msg_start,
  input  logic [BLK-1:0] iv_in,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [BLK-1:0] in_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [BLK-1:0] out_data,
  output logic           rd_en,
  output logic [AW-1:0]  rd_addr,
  output logic [BLK-1:0] rnd_state,
  output logic           rnd_first,
  output logic           rnd_last,
  input  logic [BLK-1:0] rnd_next
);
  localparam logic [AW-1:0] LAST = AW'(NR);

  eng_state_t     fsm;
  logic [AW-1:0]  rnd;
  logic [BLK-1:0] st;
  logic [BLK-1:0] chain;

  assign in_ready  = (fsm == ST_IDLE);
  assign out_valid = (fsm == ST_DONE);
  assign out_data  = st;
  assign rd_en     = (fsm == ST_RUN);
  assign rd_addr   = rnd;
  assign rnd_state = st;
  assign rnd_first = (rnd == '0);
  assign rnd_last  = (rnd == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm   <= ST_IDLE;
      rnd   <= '0;
      st    <= '0;
      chain <= '0;
    end else begin
      case (fsm)
        ST_IDLE: begin
          if (msg_start) chain <= iv_in;
          if (in_valid) begin
            st  <= in_data ^ (msg_start ? iv_in : chain);
            rnd <= '0;
            fsm <= ST_RUN;
          end
        end
        ST_RUN: begin
          st <= rnd_next;
          if (rnd == LAST) begin
            chain <= rnd_next;
            fsm   <= ST_DONE;
          end else begin
            rnd <= rnd + 1'b1;
          end
        end
        ST_DONE: begin
          if (out_ready) fsm <= ST_IDLE;
        end
        default: fsm <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cbc_aes_enc.sv
module cbc_aes_enc import aes_pkg::*; #(
  parameter int NR = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         msg_start,
  input  logic [127:0] iv_in,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [127:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [127:0] out_data,
  input  logic         key_wr_en,
  input  logic [3:0]   key_wr_addr,
  input  logic [127:0] key_wr_data,
  output logic         key_wr_ready
);
  localparam int KEYS = NR + 1;
  localparam int AW = 4;

  logic           km_rd_en;
  logic [AW-1:0]  km_rd_addr;
  logic [BLK-1:0] km_rd_data;
  logic           km_wr_fire;
  logic [BLK-1:0] rnd_state;
  logic           rnd_first;
  logic           rnd_last;
  logic [BLK-1:0] rnd_next;

  aes_keystore #(.ENTRIES(KEYS), .AW(AW)) u_keys (
    .clk      (clk),
    .rd_en    (km_rd_en),
    .rd_addr  (km_rd_addr),
    .rd_data  (km_rd_data),
    .wr_en    (key_wr_en),
    .wr_addr  (key_wr_addr),
    .wr_data  (key_wr_data),
    .wr_ready (key_wr_ready),
    .wr_fire  (km_wr_fire)
  );

  aes_round_unit u_round (
    .state_in  (rnd_state),
    .round_key (km_rd_data),
    .first     (rnd_first),
    .last      (rnd_last),
    .state_out (rnd_next)
  );

  aes_cbc_ctrl #(.NR(NR), .AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_start (msg_start),
    .iv_in     (iv_in),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .rd_en     (km_rd_en),
    .rd_addr   (km_rd_addr),
    .rnd_state (rnd_state),
    .rnd_first (rnd_first),
    .rnd_last  (rnd_last),
    .rnd_next  (rnd_next)
  );
endmodule

// File: rtl/aes_chk.sv
module aes_chk #(
  parameter int NR = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [127:0] out_data,
  input logic         key_wr_ready,
  input logic         rd_en,
  input logic         wr_fire
);
  localparam int CW = $clog2(NR + 4) + 1;
  localparam logic [CW-1:0] SAT = '1;
  localparam logic [CW-1:0] DONE_AT = CW'(NR + 1);

  // cycles since the last accepted block, saturating
  logic [CW-1:0] cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= SAT;
    else if (in_valid && in_ready) cnt <= '0;
    else if (cnt != SAT) cnt <= cnt + 1'b1;
  end

  p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (cnt == DONE_AT));

  p_reopen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> in_ready);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < DONE_AT) |-> !key_wr_ready);

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_fire));
endmodule

bind cbc_aes_enc aes_chk #(.NR(NR)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .key_wr_ready (key_wr_ready),
  .rd_en        (km_rd_en),
  .wr_fire      (km_wr_fire)
);

// File: tb/sim_cbc_aes_enc.sv
module sim_cbc_aes_enc;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         msg_start = 1'b0;
  logic [127:0] iv_in = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;
  logic         key_wr_en = 1'b0;
  logic [3:0]   key_wr_addr = '0;
  logic [127:0] key_wr_data = '0;
  logic         key_wr_ready;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbc_aes_enc u0 (.*);

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [127:0] exp_q[$];
  string        tag_q[$];
  logic [127:0] chain_m;
  logic [127:0] rk_m [0:10];
  logic [7:0]   gexp [0:255];
  logic [7:0]   glog [0:255];

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, expv);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  // ---- independent reference model (log/antilog field arithmetic) ----
  function automatic logic [7:0] dbl(input logic [7:0] a);
    logic [7:0] r;
    r = a << 1;
    if (a[7]) r = r ^ 8'h1b;
    return r;
  endfunction

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    if (a == 0 || b == 0) return 8'h00;
    return gexp[(int'(glog[a]) + int'(glog[b])) % 255];
  endfunction

  function automatic logic [7:0] bsbox(input logic [7:0] x);
    logic [7:0] inv;
    logic [7:0] o;
    inv = (x == 0) ? 8'h00 : gexp[(255 - int'(glog[x])) % 255];
    for (int i = 0; i < 8; i++)
      o[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ (8'h63 >> i) & 1'b1;
    return o;
  endfunction

  function automatic logic [127:0] model_enc(input logic [127:0] blk);
    logic [7:0] s [4][4];
    logic [7:0] t [4][4];
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        s[r][c] = blk[127-8*(4*c+r) -: 8] ^ rk_m[0][127-8*(4*c+r) -: 8];
    for (int k = 1; k <= 10; k++) begin
      for (int r = 0; r < 4; r++)
        for (int c = 0; c < 4; c++)
          t[r][c] = bsbox(s[r][(c+r)%4]);
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          if (k < 10)
            s[r][c] = gm(8'h02, t[r][c]) ^ gm(8'h03, t[(r+1)%4][c]) ^ t[(r+2)%4][c] ^ t[(r+3)%4][c];
          else
            s[r][c] = t[r][c];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          s[r][c] = s[r][c] ^ rk_m[k][127-8*(4*c+r) -: 8];
    end
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        model_enc[127-8*(4*c+r) -: 8] = s[r][c];
  endfunction

  task automatic expand_key(input logic [127:0] key);
    logic [31:0] w [0:43];
    logic [31:0] tmp;
    logic [7:0]  rc;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      tmp = w[i-1];
      if (i % 4 == 0) begin
        tmp = {tmp[23:0], tmp[31:24]};
        tmp = {bsbox(tmp[31:24]), bsbox(tmp[23:16]), bsbox(tmp[15:8]), bsbox(tmp[7:0])};
        tmp = tmp ^ {rc, 24'h0};
        rc = dbl(rc);
      end
      w[i] = w[i-4] ^ tmp;
    end
    for (int k = 0; k < 11; k++) rk_m[k] = {w[4*k], w[4*k+1], w[4*k+2], w[4*k+3]};
  endtask

  // ---- driver side ----
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic key_write(input logic [3:0] a, input logic [127:0] d, output int stalls);
    stalls = 0;
    key_wr_en = 1'b1;
    key_wr_addr = a;
    key_wr_data = d;
    while (!key_wr_ready) begin
      tick();
      stalls++;
    end
    tick();
    key_wr_en = 1'b0;
  endtask

  task automatic push_exp(input logic [127:0] x, input string tag);
    chain_m = model_enc(x ^ chain_m);
    exp_q.push_back(chain_m);
    tag_q.push_back(tag);
  endtask

  task automatic send(input logic [127:0] blk, input string tag);
    in_valid = 1'b1;
    in_data = blk;
    while (!in_ready) tick();
    push_exp(blk, tag);
    tick();
    in_valid = 1'b0;
  endtask

  task automatic start_msg(input logic [127:0] iv);
    while (!in_ready) tick();
    msg_start = 1'b1;
    iv_in = iv;
    chain_m = iv;
    tick();
    msg_start = 1'b0;
  endtask

  task automatic send_with_start(input logic [127:0] iv, input logic [127:0] blk, input string tag);
    while (!in_ready) tick();
    msg_start = 1'b1;
    iv_in = iv;
    in_valid = 1'b1;
    in_data = blk;
    chain_m = iv;
    push_exp(blk, tag);
    tick();
    msg_start = 1'b0;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while (exp_q.size() != 0 && guard < 2000) begin
      tick();
      guard++;
    end
    tick();
    tick();
  endtask

  // ---- output backpressure ----
  bit bp_on = 0;
  logic [15:0] lfsr = 16'hace1;
  always begin
    @(posedge clk);
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (bp_on) out_ready = lfsr[0] & lfsr[5];
  end

  // ---- monitor / scoreboard ----
  bit           prev_hold = 0;
  logic [127:0] prev_data = '0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (prev_hold) begin
        chk("R7 hold valid", {127'd0, out_valid}, 128'd1);
        chk("R7 hold data", out_data, prev_data);
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk("R3 unexpected output", out_data, 128'hx);
        end else begin
          chk(tag_q.pop_front(), out_data, exp_q.pop_front());
        end
      end
      prev_hold = out_valid && !out_ready;
      prev_data = out_data;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    int stalls;
    int lat;
    logic [127:0] newk;
    logic [7:0] v;
    v = 8'h01;
    for (int i = 0; i < 255; i++) begin
      gexp[i] = v;
      glog[v] = 8'(i);
      v = v ^ dbl(v);
    end
    gexp[255] = gexp[0];
    glog[0] = 8'h00;
    chain_m = '0;

    repeat (3) @(posedge clk);
    #1;
    chk("R1 out_valid reset", {127'd0, out_valid}, 128'd0);
    chk("R1 in_ready reset", {127'd0, in_ready}, 128'd1);
    chk("R1 key_wr_ready reset", {127'd0, key_wr_ready}, 128'd1);
    rst_n = 1'b1;
    tick();

    // R9: load round keys while idle, no stall
    expand_key(128'h2b7e151628aed2a6abf7158809cf4f3c);
    for (int k = 0; k < 11; k++) begin
      key_write(4'(k), rk_m[k], stalls);
      chk("R9 idle write no stall", 128'(stalls), 128'd0);
    end

    // R2: standard vector, zero chaining value
    chk("R2 model sanity", model_enc(128'h3243f6a8885a308d313198a2e0370734),
        128'h3925841d02dc09fbdc118597196a0b32);
    start_msg('0);
    out_ready = 1'b0;
    send(128'h3243f6a8885a308d313198a2e0370734, "R2 standard vector");
    // R6: latency and closed gate
    lat = 0;
    while (!out_valid && lat < 40) begin
      chk("R6 gate closed", {127'd0, in_ready}, 128'd0);
      tick();
      lat++;
    end
    chk("R6 latency", 128'(lat), 128'd11);
    tick();
    tick();
    chk("R6 gate closed while output waits", {127'd0, in_ready}, 128'd0);
    out_ready = 1'b1;
    tick();
    chk("R6 gate reopens", {127'd0, in_ready}, 128'd1);
    drain();

    // R3: chained blocks under backpressure
    start_msg(128'h000102030405060708090a0b0c0d0e0f);
    bp_on = 1;
    send(128'h6bc1bee22e409f96e93d7e117393172a, "R3 chain blk0");
    send(128'hae2d8a571e03ac9c9eb76fac45af8e51, "R3 chain blk1");
    send(128'h30c81c46a35ce411e5fbc1191a0a52ef, "R3 chain blk2");
    send(128'hf69f2445df4f9b17ad2b417be66c3710, "R3 chain blk3");
    drain();
    bp_on = 0;
    out_ready = 1'b1;

    // R4: restart coincident with accept, and restart alone
    send_with_start(128'hffeeddccbbaa99887766554433221100, 128'h0123456789abcdeffedcba9876543210,
                    "R4 start with accept");
    send(128'h11111111222222223333333344444444, "R4 chain after start");
    drain();
    start_msg(128'h5a5a5a5aa5a5a5a5deadbeefcafef00d);
    send(128'h00000000000000000000000000000000, "R4 start alone");
    drain();

    // R5: msg_start during a running block is ignored
    send(128'h0f0e0d0c0b0a09080706050403020100, "R5 blk before pulse");
    msg_start = 1'b1;
    iv_in = 128'h1234123412341234abcdabcdabcdabcd;
    tick();
    msg_start = 1'b0;
    send(128'h89898989898989898989898989898989, "R5 chain unaffected");
    drain();

    // R8: host write held across a running block
    out_ready = 1'b0;
    send(128'h7777777788888888999999990000aaaa, "R8 running block old key");
    newk = 128'hc0ffee00c0ffee00c0ffee00c0ffee00;
    chk("R8 ready low in rounds", {127'd0, key_wr_ready}, 128'd0);
    key_write(4'd10, newk, stalls);
    chk("R8 stall length", 128'(stalls), 128'd11);
    rk_m[10] = newk;
    out_ready = 1'b1;
    send(128'hbbbbbbbbccccccccddddddddeeeeeeee, "R8 next block new key");
    drain();

    // R9: restore the key while idle and use it at once
    expand_key(128'h2b7e151628aed2a6abf7158809cf4f3c);
    key_write(4'd10, rk_m[10], stalls);
    chk("R9 restore no stall", 128'(stalls), 128'd0);
    start_msg('0);
    send(128'h3243f6a8885a308d313198a2e0370734, "R9 restored key vector");
    drain();
    chk("R3 scoreboard empty", 128'(exp_q.size()), 128'd0);

    summary();
  end
endmodule